// File: doc/BRIEF.md
# Program Fetch External Bus Interface

This block sits between an 8-bit controller core and its program memory. It keeps the 16-bit program counter, takes a fetch request from the core, and sends each fetch to one of two places. The first is a small on-chip code store covering the lowest 4 KB. The second is an external memory reached over a narrow bus. The choice depends on a strap input that is captured during reset. When the strap is high, the lowest 4 KB come from the on-chip store and everything above comes from outside. When the strap is low, every address goes to external memory.

The external bus uses one 8-bit port for two jobs in turn. It first carries the low address byte, marked by a latch strobe so that an external register can hold it. It then turns around to receive the code byte while an active-low read strobe is asserted. A second 8-bit port drives the high address byte for the whole access.

The core asks for the next sequential byte with a request. It can also redirect the counter to a new address in the same cycle. It gets back the byte, the address it came from, and a one-cycle valid pulse.

Top module: `pfx_fetch_bus`

## Requirements
- R1: While reset is held (synchronous, active low), the latch strobe is low, the read strobe is high, the multiplexed port is not driven, valid is low and ready is high. The program counter is 0000H, so the first fetch without a jump reads address 0000H.
- R2: With the strap captured low, every fetch from 0000H to FFFFH runs an external access and returns the byte seen on the bus input.
- R3: With the strap captured high, fetches below 1000H come from the on-chip store and fetches from 1000H upward run an external access. The on-chip byte at address a is 5AH XOR a[7:0] XOR a[11:4].
- R4: An on-chip fetch raises valid exactly one clock after the request is accepted. It asserts neither strobe and does not drive the multiplexed port.
- R5: External phase 1 lasts the first clock after acceptance. In it the latch strobe is high and the multiplexed port is driven with the low address byte.
- R6: External phase 2 lasts the next clock. In it the latch strobe is low and the port still drives the low address byte.
- R7: External phase 3 lasts the third clock. In it the read strobe is low and the port is released (output enable low).
- R8: The high address byte is on its port during all three phases. The bus input is sampled at the edge that ends phase 3. The byte is returned with valid in the following cycle, and in that same cycle the read strobe is high again.
- R9: The strap is captured only while reset is held. Later changes have no effect until the next reset.
- R10: Each accepted fetch uses the jump address when jump is high and the counter otherwise. The counter then becomes that address plus one, wrapping from FFFFH to 0000H. The returned address shows the fetched location.
- R11: Ready is low during the three external phases, and a request or jump seen while ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_en_strap_i | input | 1 | High selects on-chip store for the low 4 KB; captured in reset |
| fetch_req_i | input | 1 | Core asks for a fetch |
| fetch_jmp_i | input | 1 | Use the jump address for this fetch |
| fetch_jmp_addr_i | input | 16 | Jump target |
| fetch_ready_o | output | 1 | Block can accept a request |
| fetch_valid_o | output | 1 | One-cycle pulse with returned byte |
| fetch_data_o | output | 8 | Fetched code byte |
| fetch_addr_o | output | 16 | Address of the fetched byte |
| bus_ad_o | output | 8 | Multiplexed port, address byte out |
| bus_ad_oe_o | output | 1 | Output enable of the multiplexed port |
| bus_ad_i | input | 8 | Multiplexed port, code byte in |
| bus_ahi_o | output | 8 | High address byte |
| bus_alatch_o | output | 1 | Address latch strobe, active high |
| bus_rd_n_o | output | 1 | Program read strobe, active low |

## Verification
The hardest case to reach from the ports is a strap change that happens after reset has been released. The stimulus raises the strap, releases reset, and fetches on-chip. It then drops the strap in mid-run and fetches from inside the low 4 KB again; the byte must still come from the on-chip pattern and no strobe may move. A second hard case is a request and jump held high through an external access. The bench drives a jump target only while ready is low, and the reference model expects the next fetch to continue from the counter.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int PFX_AW = 16;
    localparam int PFX_DW = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_HOLD = 2'd2,
        PH_READ = 2'd3
    } pfx_phase_e;

    typedef struct packed {
        pfx_phase_e          phase;
        logic [PFX_AW-1:0]   pc;
        logic [PFX_AW-1:0]   addr;
        logic                strap;
        logic                valid;
        logic [PFX_DW-1:0]   data;
    } pfx_state_t;
endpackage

// File: rtl/pfx_region.sv
module pfx_region #(
    parameter int AW     = 16,
    parameter int ROM_AW = 12
) (
    input  logic          strap_i,
    input  logic [AW-1:0] addr_i,
    output logic          onchip_o
);
    localparam int HI_W = AW - ROM_AW;

    logic [HI_W-1:0] hi_bits;

    always_comb begin
        hi_bits  = addr_i[AW-1:ROM_AW];
        onchip_o = strap_i && (hi_bits == '0);
    end
endmodule

// File: rtl/pfx_rom.sv
module pfx_rom #(
    parameter int          ROM_AW = 12,
    parameter int          DW     = 8,
    parameter int          FOLD   = 4,
    parameter logic [7:0]  SEED   = 8'h5A
) (
    input  logic [ROM_AW-1:0] addr_i,
    output logic [DW-1:0]     data_o
);
    // Content is a folded XOR of the address with a constant seed.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i + FOLD < ROM_AW) begin : g_fold
            assign data_o[i] = SEED[i % 8] ^ addr_i[i] ^ addr_i[i + FOLD];
        end else begin : g_plain
            assign data_o[i] = SEED[i % 8] ^ addr_i[i];
        end
    end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
    import pfx_pkg::*;
#(
    parameter int AW = PFX_AW,
    parameter int DW = PFX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_i,
    input  logic          req_i,
    input  logic          jmp_i,
    input  logic [AW-1:0] jmp_addr_i,
    input  logic          onchip_i,
    input  logic [DW-1:0] rom_data_i,
    input  logic [DW-1:0] ad_i,
    output logic [AW-1:0] cand_addr_o,
    output logic          strap_q_o,
    output logic          ready_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [DW-1:0] ahi_o,
    output logic          alatch_o,
    output logic          rd_n_o
);
    localparam int LO_W = AW / 2;

    pfx_state_t st_q, st_d;

    always_comb begin
        cand_addr_o = jmp_i ? jmp_addr_i : st_q.pc;
        st_d        = st_q;
        st_d.valid  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.addr = cand_addr_o;
                    st_d.pc   = cand_addr_o + 1'b1;
                    if (onchip_i) begin
                        st_d.valid = 1'b1;
                        st_d.data  = rom_data_i;
                    end else begin
                        st_d.phase = PH_ADDR;
                    end
                end
            end
            PH_ADDR: st_d.phase = PH_HOLD;
            PH_HOLD: st_d.phase = PH_READ;
            PH_READ: begin
                st_d.phase = PH_IDLE;
                st_d.valid = 1'b1;
                st_d.data  = ad_i;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.pc    <= '0;
            st_q.addr  <= '0;
            st_q.strap <= strap_i;
            st_q.valid <= 1'b0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        strap_q_o = st_q.strap;
        ready_o   = (st_q.phase == PH_IDLE);
        valid_o   = st_q.valid;
        data_o    = st_q.data;
        addr_o    = st_q.addr;
        alatch_o  = (st_q.phase == PH_ADDR);
        ad_oe_o   = (st_q.phase == PH_ADDR) || (st_q.phase == PH_HOLD);
        ad_o      = ad_oe_o ? st_q.addr[LO_W-1:0] : '0;
        ahi_o     = st_q.addr[AW-1:LO_W];
        rd_n_o    = (st_q.phase != PH_READ);
    end

    // R4
    onchip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && req_i && onchip_i) |=> (valid_o && !alatch_o && rd_n_o && !ad_oe_o));

    // R6
    latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alatch_o |=> (!alatch_o && ad_oe_o && $stable(ad_o)));

    // R7
    read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> (!ad_oe_o && $past(ad_oe_o) && !$past(alatch_o)));

    // R8
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |=> (rd_n_o && valid_o));

    // R8
    ahi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !$past(ready_o)) |-> $stable(ahi_o));

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(strap_q_o));

    // R11
    busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && req_i) |=> $stable(addr_o));
endmodule

// File: rtl/pfx_fetch_bus.sv
module pfx_fetch_bus
    import pfx_pkg::*;
#(
    parameter int AW           = PFX_AW,
    parameter int DW           = PFX_DW,
    parameter int ONCHIP_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rom_en_strap_i,
    input  logic          fetch_req_i,
    input  logic          fetch_jmp_i,
    input  logic [AW-1:0] fetch_jmp_addr_i,
    output logic          fetch_ready_o,
    output logic          fetch_valid_o,
    output logic [DW-1:0] fetch_data_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_ad_oe_o,
    input  logic [DW-1:0] bus_ad_i,
    output logic [DW-1:0] bus_ahi_o,
    output logic          bus_alatch_o,
    output logic          bus_rd_n_o
);
    localparam int ROM_AW = $clog2(ONCHIP_BYTES);

    logic [AW-1:0] cand_addr;
    logic          strap_q;
    logic          onchip;
    logic [DW-1:0] rom_data;

    pfx_region #(.AW(AW), .ROM_AW(ROM_AW)) u_region (
        .strap_i  (strap_q),
        .addr_i   (cand_addr),
        .onchip_o (onchip)
    );

    pfx_rom #(.ROM_AW(ROM_AW), .DW(DW)) u_rom (
        .addr_i (cand_addr[ROM_AW-1:0]),
        .data_o (rom_data)
    );

    pfx_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (rom_en_strap_i),
        .req_i       (fetch_req_i),
        .jmp_i       (fetch_jmp_i),
        .jmp_addr_i  (fetch_jmp_addr_i),
        .onchip_i    (onchip),
        .rom_data_i  (rom_data),
        .ad_i        (bus_ad_i),
        .cand_addr_o (cand_addr),
        .strap_q_o   (strap_q),
        .ready_o     (fetch_ready_o),
        .valid_o     (fetch_valid_o),
        .data_o      (fetch_data_o),
        .addr_o      (fetch_addr_o),
        .ad_o        (bus_ad_o),
        .ad_oe_o     (bus_ad_oe_o),
        .ahi_o       (bus_ahi_o),
        .alatch_o    (bus_alatch_o),
        .rd_n_o      (bus_rd_n_o)
    );
endmodule

// File: tb/sim_pfx_fetch_bus.sv
`timescale 1ns/1ps
module sim_pfx_fetch_bus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        req = 1'b0;
    logic        jmp = 1'b0;
    logic [15:0] jaddr = 16'h0000;
    logic        ready, valid, ad_oe, alatch, rd_n;
    logic [7:0]  data, ad_o, ad_i, ahi;
    logic [15:0] faddr;
    logic [7:0]  latched = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfx_fetch_bus u0 (
        .clk(clk), .rst_n(rst_n), .rom_en_strap_i(strap),
        .fetch_req_i(req), .fetch_jmp_i(jmp), .fetch_jmp_addr_i(jaddr),
        .fetch_ready_o(ready), .fetch_valid_o(valid), .fetch_data_o(data),
        .fetch_addr_o(faddr), .bus_ad_o(ad_o), .bus_ad_oe_o(ad_oe),
        .bus_ad_i(ad_i), .bus_ahi_o(ahi), .bus_alatch_o(alatch), .bus_rd_n_o(rd_n)
    );

    function automatic logic [7:0] rom_ref(input logic [15:0] a);
        return 8'h5A ^ a[7:0] ^ a[11:4];
    endfunction

    function automatic logic [7:0] xmem_ref(input logic [15:0] a);
        return (a[15:8] ^ 8'hC3) + a[7:0];
    endfunction

    // External memory with its own address latch
    always @(negedge alatch) latched = ad_o;
    assign ad_i = !rd_n ? xmem_ref({ahi, latched}) : 8'hEE;

    // Reference model
    int          m_phase = 0;
    logic [15:0] m_pc = 16'h0, m_addr = 16'h0;
    logic        m_valid = 1'b0, m_strap = 1'b0, m_started = 1'b0, strap_moved = 1'b0;
    logic [7:0]  m_data = 8'h0;
    string       m_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pc = 16'h0; m_addr = 16'h0; m_valid = 1'b0;
            m_strap = strap; m_started = 1'b1; strap_moved = 1'b0;
        end else begin
            m_valid = 1'b0;
            case (m_phase)
                0: if (req) begin
                    m_addr = jmp ? jaddr : m_pc;
                    m_pc   = m_addr + 16'h1;
                    m_tag  = strap_moved ? "R9" : (m_strap ? "R3" : "R2");
                    if (m_strap && m_addr < 16'h1000) begin
                        m_valid = 1'b1;
                        m_data  = rom_ref(m_addr);
                    end else begin
                        m_phase = 1;
                    end
                end
                1: m_phase = 2;
                2: m_phase = 3;
                default: begin
                    m_phase = 0;
                    m_valid = 1'b1;
                    m_data  = xmem_ref(m_addr);
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison
    always @(negedge clk) begin
        if (m_started && !done) begin
            string t;
            t = !rst_n ? "R1" : "";
            chk(ready == (m_phase == 0), (t != "") ? t : "R11", "ready", 16'(ready), 16'(m_phase == 0));
            chk(alatch == (m_phase == 1), (t != "") ? t : "R5", "latch", 16'(alatch), 16'(m_phase == 1));
            chk(ad_oe == (m_phase == 1 || m_phase == 2), (t != "") ? t : "R6", "oe", 16'(ad_oe),
                16'(m_phase == 1 || m_phase == 2));
            chk(rd_n == (m_phase != 3), (t != "") ? t : "R7", "rd_n", 16'(rd_n), 16'(m_phase != 3));
            chk(valid == m_valid, (t != "") ? t : "R4", "valid", 16'(valid), 16'(m_valid));
            if (rst_n && (m_phase == 1 || m_phase == 2))
                chk(ad_o == m_addr[7:0], (m_phase == 1) ? "R5" : "R6", "ad_o", 16'(ad_o), 16'(m_addr[7:0]));
            if (rst_n && m_phase != 0)
                chk(ahi == m_addr[15:8], "R8", "ahi", 16'(ahi), 16'(m_addr[15:8]));
            if (rst_n && m_valid) begin
                chk(data == m_data, m_tag, "data", 16'(data), 16'(m_data));
                chk(faddr == m_addr, "R10", "addr", faddr, m_addr);
            end
        end
    end

    task automatic cyc(input bit r, input bit j, input logic [15:0] a);
        req = r; jmp = j; jaddr = a;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit s);
        rst_n = 1'b0; strap = s; req = 1'b0; jmp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R11: hold request and drive a bogus jump only while busy
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            if (m_phase != 0) cyc(1'b1, 1'b1, 16'h0050);
            else cyc(1'b1, 1'b0, 16'h0000);
        end
    endtask

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        @(negedge clk);
        do_reset(1'b1);                 // R1 checked during reset cycles
        run(4);                         // R3 R4 R10 on-chip from 0000H
        cyc(1'b1, 1'b1, 16'h0FFE);      // R3 boundary
        run(14);                        // 0FFF on-chip, 1000H external, R5-R8, R11
        cyc(1'b0, 1'b0, 16'h0);
        cyc(1'b0, 1'b0, 16'h0);
        while (m_phase != 0) cyc(1'b0, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 16'hFFFF);      // R10 wrap
        run(8);
        while (m_phase != 0) cyc(1'b0, 1'b0, 16'h0);
        strap = 1'b0; strap_moved = 1'b1; // R9
        cyc(1'b1, 1'b1, 16'h0020);
        run(3);
        do_reset(1'b0);                 // R2 all external
        run(10);
        while (m_phase != 0) cyc(1'b0, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 16'h0FFF);
        run(10);
        while (m_phase != 0) cyc(1'b0, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 16'h8000);
        run(6);
        do_reset(1'b1);
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0], lf[1] & lf[2], {lf[3] ? 4'h0 : lf[15:12], lf[11:0]});
        end
        cyc(1'b0, 1'b0, 16'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule